// File: doc/BRIEF.md
# Serial EEPROM Device Responder

This block models the device side of a small serial EEPROM. The array is organised as 16-bit words. A host controls it through a select line, a serial clock and a data input, and it answers on one data output. The responder samples these lines with the system clock. Each instruction is clocked in on rising edges of the serial clock. The block keeps its own word array, a write-enable latch and a programming timer. This lets a host controller or driver be exercised against a device that reports busy and ready.

An instruction starts with a 1 bit, then a two-bit operation code, then the address, most significant bit first. The address width is a parameter: 6 bits for the small array, 8 for the large one. The operation code 00 forms an extended group, and the two top address bits choose its member. After any programming instruction the host drops select and raises it again. It then polls the data output, which reads 0 while the array is busy and 1 once the array is ready. The busy time, in system clock cycles, is a parameter.

Top module: `uwire_eeprom`

## Requirements
- R1: After reset the write-enable latch is clear and every word of the array reads 16'hFFFF.
- R2: A READ (start 1, opcode 10, address) drives 0 on data-out right after the last address bit. Each following rising serial-clock edge then presents the next bit of the addressed word, D15 first and D0 last.
- R3: With writes enabled, WRITE (opcode 01, address, then 16 data bits MSB first) stores the data word at the address.
- R4: With writes enabled, ERASE (opcode 11, address) sets the addressed word to 16'hFFFF.
- R5: With writes enabled, the opcode 00 group uses the top two address bits. Value 10 (ERAL) sets every word to 16'hFFFF, and value 01 (WRAL, followed by 16 data bits) writes the data word to every address.
- R6: Opcode 00 with top address bits 11 sets the write-enable latch, and 00 clears it. While the latch is clear, WRITE, ERASE, ERAL and WRAL change no word and start no busy period.
- R7: An accepted programming instruction starts a busy period of BUSY_CYCLES clocks. While select is high and the array is busy, data-out is 0. Once the period ends, data-out reads 1 with select high and no instruction in progress.
- R8: Dropping select at any point abandons a partial instruction without effect, and the decoder waits for a new start bit.
- R9: Data-out is 0 whenever select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; bits are taken on its rising edges |
| di | input | 1 | Serial data from the host |
| dout | output | 1 | Serial read data, or ready status between instructions |

## Verification
The assertions check on every cycle that data-out stays low while unselected or busy. They also check that a busy period can begin only with the write-enable latch set, that the busy timer only counts down within its bound, and that a drop of select returns the decoder to idle. The values stored by WRITE, ERASE, ERAL and WRAL, the dummy zero and bit order of READ, and the loss of a half-sent instruction show only in the bench's scenarios. The bench follows each such instruction with reads against its own model of the array.

// File: rtl/uwire_eeprom.sv
module uwire_eeprom #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CMD_W = ADDR_W + 2;
  localparam int MAXB  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int CNT_W = $clog2(MAXB);
  localparam int BW    = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] LAST_DAT = CNT_W'(DATA_W - 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_DATA, S_READ, S_HOLD} st_t;

  st_t               st;
  logic              sk_q, wen;
  logic [CMD_W-1:0]  cmd;
  logic [DATA_W-1:0] dsr;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W:0]   obuf;
  logic [BW-1:0]     bcnt;
  logic [DATA_W-1:0] mem [DEPTH];

  wire               rise  = sk & ~sk_q;
  wire               busy  = bcnt != '0;
  wire               idle  = st == S_IDLE;
  wire [CMD_W-1:0]   cmd_n = {cmd[CMD_W-2:0], di};
  wire [1:0]         op    = cmd_n[CMD_W-1 -: 2];
  wire [1:0]         sub   = cmd_n[ADDR_W-1 -: 2];
  wire [ADDR_W-1:0]  addr  = cmd_n[ADDR_W-1:0];
  wire [1:0]         cop   = cmd[CMD_W-1 -: 2];
  wire [ADDR_W-1:0]  caddr = cmd[ADDR_W-1:0];
  wire [DATA_W-1:0]  dat_n = {dsr[DATA_W-2:0], di};

  assign dout = cs & ((st == S_READ & obuf[DATA_W]) | (idle & ~busy));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      sk_q <= 1'b0;
      wen  <= 1'b0;
      cmd  <= '0;
      dsr  <= '0;
      cnt  <= '0;
      obuf <= '0;
      bcnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      sk_q <= sk;
      if (busy) bcnt <= bcnt - 1'b1;
      if (!cs) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else if (rise) begin
        case (st)
          S_IDLE: if (di && !busy) begin
            st  <= S_CMD;
            cnt <= '0;
          end
          S_CMD: begin
            cmd <= cmd_n;
            cnt <= cnt + 1'b1;
            if (cnt == LAST_CMD) begin
              cnt <= '0;
              st  <= S_HOLD;
              case (op)
                2'b10: begin
                  obuf <= {1'b0, mem[addr]};
                  st   <= S_READ;
                end
                2'b01: st <= S_DATA;
                2'b11: if (wen) begin
                  mem[addr] <= '1;
                  bcnt      <= BW'(BUSY_CYCLES);
                end
                default: case (sub)
                  2'b11: wen <= 1'b1;
                  2'b00: wen <= 1'b0;
                  2'b01: st  <= S_DATA;
                  default: if (wen) begin
                    for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
                    bcnt <= BW'(BUSY_CYCLES);
                  end
                endcase
              endcase
            end
          end
          S_DATA: begin
            dsr <= dat_n;
            cnt <= cnt + 1'b1;
            if (cnt == LAST_DAT) begin
              cnt <= '0;
              st  <= S_HOLD;
              if (wen) begin
                bcnt <= BW'(BUSY_CYCLES);
                if (cop == 2'b01) mem[caddr] <= dat_n;
                else for (int i = 0; i < DEPTH; i++) mem[i] <= dat_n;
              end
            end
          end
          S_READ: obuf <= {obuf[DATA_W-1:0], 1'b0};
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/uwire_eeprom_chk.sv
module uwire_eeprom_chk #(
  parameter int BUSY_CYCLES = 200,
  parameter int BW          = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          dout,
  input logic          busy,
  input logic          wen,
  input logic          idle,
  input logic [BW-1:0] bcnt
);
  AST_QUIET_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n) !cs |-> !dout); // R9
  AST_BUSY_READS_LOW: assert property (@(posedge clk) disable iff (!rst_n) (cs && busy) |-> !dout); // R7
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n) 32'(bcnt) <= BUSY_CYCLES); // R7
  AST_BUSY_DRAINS: assert property (@(posedge clk) disable iff (!rst_n) busy |=> bcnt == $past(bcnt) - 1'b1); // R7
  AST_PROG_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> wen); // R6
  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !cs |=> idle); // R8
endmodule

bind uwire_eeprom uwire_eeprom_chk #(.BUSY_CYCLES(BUSY_CYCLES), .BW(BW)) chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .dout(dout),
  .busy(busy), .wen(wen), .idle(idle), .bcnt(bcnt)
);

// File: tb/uwire_eeprom_test.sv
`timescale 1ns/1ps
module uwire_eeprom_test;
  localparam int AW   = 6;
  localparam int BUSY = 200;

  logic clk = 0, rst_n = 0, cs = 0, sk = 0, di = 0;
  logic dout;
  int   n_run = 0, n_fail = 0;
  bit   finished = 0;

  logic [16:0] exp_q[$];
  logic [16:0] obs_q[$];
  string       tag_q[$];

  logic [15:0] model [1<<AW];
  bit          wen_m;

  uwire_eeprom #(.ADDR_W(AW), .DATA_W(16), .BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .dout(dout));

  always #4 clk = ~clk;

  always @(negedge clk) begin
    while (exp_q.size() > 0 && obs_q.size() > 0) begin
      logic [16:0] e, o;
      string t;
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (e !== o) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", t, o, e);
      end
    end
  end

  task automatic expect_item(input string t, input logic [16:0] e, input logic [16:0] o);
    tag_q.push_back(t);
    exp_q.push_back(e);
    obs_q.push_back(o);
  endtask

  task automatic clk_bit(input logic b, output logic q);
    di = b;
    @(negedge clk) sk = 1;
    repeat (2) @(negedge clk);
    q = dout;
    sk = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic select();
    cs = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic deselect();
    cs = 0;
    di = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [7:0] a, output logic q);
    select();
    clk_bit(1'b1, q);
    clk_bit(op[1], q);
    clk_bit(op[0], q);
    for (int i = AW - 1; i >= 0; i--) clk_bit(a[i], q);
  endtask

  task automatic do_read(input logic [7:0] a, input string t);
    logic q;
    logic [16:0] got;
    send_cmd(2'b10, a, q);
    got[16] = q;
    for (int i = 15; i >= 0; i--) begin
      clk_bit(1'b0, q);
      got[i] = q;
    end
    deselect();
    expect_item(t, {1'b0, model[a[AW-1:0]]}, got);
  endtask

  task automatic send_data(input logic [15:0] d);
    logic q;
    for (int i = 15; i >= 0; i--) clk_bit(d[i], q);
  endtask

  task automatic poll(input bit prog, input string t);
    select();
    expect_item({t, " status"}, 17'(!(prog && wen_m)), 17'(dout));
    if (prog && wen_m) begin
      repeat (BUSY + 20) @(negedge clk);
      expect_item({t, " ready"}, 17'd1, 17'(dout));
    end
    deselect();
  endtask

  task automatic do_write(input logic [7:0] a, input logic [15:0] d, input string t);
    logic q;
    send_cmd(2'b01, a, q);
    send_data(d);
    deselect();
    if (wen_m) model[a[AW-1:0]] = d;
    poll(1, t);
  endtask

  task automatic do_erase(input logic [7:0] a, input string t);
    logic q;
    send_cmd(2'b11, a, q);
    deselect();
    if (wen_m) model[a[AW-1:0]] = 16'hFFFF;
    poll(1, t);
  endtask

  task automatic do_ext(input logic [1:0] s, input logic [15:0] d, input string t);
    logic q;
    send_cmd(2'b00, {s, 6'b000000} >> (8 - AW), q);
    if (s == 2'b01) send_data(d);
    deselect();
    case (s)
      2'b11: wen_m = 1;
      2'b00: wen_m = 0;
      2'b10: if (wen_m) for (int i = 0; i < (1<<AW); i++) model[i] = 16'hFFFF;
      default: if (wen_m) for (int i = 0; i < (1<<AW); i++) model[i] = d;
    endcase
    poll(s == 2'b10 || s == 2'b01, t);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic q;
    for (int i = 0; i < (1<<AW); i++) model[i] = 16'hFFFF;
    wen_m = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_item("R9 reset unselected dout", 17'd0, 17'(dout));
    select();
    expect_item("R1 reset ready", 17'd1, 17'(dout));
    deselect();
    do_read(8'd5, "R1 R2 read after reset");
    do_write(8'd5, 16'hA5C3, "R6 write while disabled");
    do_read(8'd5, "R6 word kept");
    do_ext(2'b11, 16'h0, "R6 enable");
    do_write(8'd5, 16'hA5C3, "R3 R7 write");
    do_read(8'd5, "R3 R2 readback");
    do_write(8'd63, 16'h1234, "R3 write top");
    do_write(8'd0, 16'h8001, "R3 write zero");
    do_read(8'd63, "R3 top readback");
    do_read(8'd0, "R3 zero readback");
    do_erase(8'd5, "R4 erase");
    do_read(8'd5, "R4 erased word");
    do_read(8'd0, "R4 neighbour kept");
    do_ext(2'b01, 16'h5A5A, "R5 write all");
    do_read(8'd0, "R5 wral word 0");
    do_read(8'd37, "R5 wral word 37");
    do_ext(2'b10, 16'h0, "R5 erase all");
    do_read(8'd63, "R5 eral word 63");
    send_cmd(2'b01, 8'd7, q);
    for (int i = 0; i < 5; i++) clk_bit(1'b0, q);
    deselect();
    select();
    expect_item("R8 abort no busy", 17'd1, 17'(dout));
    deselect();
    do_read(8'd7, "R8 aborted write");
    do_write(8'd9, 16'h0F0F, "R3 write before disable");
    do_ext(2'b00, 16'h0, "R6 disable");
    do_erase(8'd9, "R6 erase while disabled");
    do_read(8'd9, "R6 erase ignored");
    do_ext(2'b10, 16'h0, "R6 eral while disabled");
    do_read(8'd9, "R6 eral ignored");
    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule